// File: doc/BRIEF.md
# Locked Burst Frame Write Master

This block moves a stream of 8-bit pixel bytes from an upstream capture path into a memory slave on a shared on-chip bus. It wins the bus from the arbiter, locks it, and writes a whole frame as one sequential burst. At the start of each frame the write address returns to a fixed base, so each frame overwrites the one before it. A small FIFO sits between the capture side and the bus. Pixels keep arriving during arbitration gaps and while a burst is restarted, and the FIFO holds them.

The slave can interrupt the burst in two ways. A retry sends the master back to arbitration, and the burst resumes at the first byte the slave did not acknowledge. An error acknowledge or a timeout ends the frame at once and frees the bus. A one-cycle done pulse marks a completed frame. A sticky error output reports an aborted frame, and a sticky overflow output reports a byte lost at the FIFO. The next frame start clears both.

Top module: `locked_burst_writer`

## Requirements
- R1: After reset, the following outputs are all low and `bus_wdata` is zero: `bus_req`, `bus_sel`, `bus_seq`, `bus_be`, `bus_lock`, `frame_done`, `err_status` and `ovf_status`.
- R2: After `frame_start` is seen in idle, `bus_req` stays high until `bus_grant` is seen. `bus_sel` is never high in a cycle where `bus_req` is high.
- R3: In the cycle after `bus_req` and `bus_grant` are both high, `bus_req` is low and `bus_lock` is high. If the FIFO holds a byte, `bus_sel`, `bus_seq` and `bus_be` are also high in that cycle.
- R4: Each frame starts at `BASE_ADDR`. An acknowledged beat is a cycle with `bus_sel` and `xfer_ack` high and no retry, error or timeout. `bus_addr` rises by one after each acknowledged beat and holds in every other cycle.
- R5: `bus_seq` is high with `bus_sel` on every beat of the frame except the final beat (beat index `FRAME_BYTES-1`), where it is low.
- R6: `frame_done` is high for exactly one cycle, the cycle after the final beat is acknowledged. In that cycle `bus_sel`, `bus_be` and `bus_lock` are low. `bus_wdata` is zero whenever `bus_sel` is low.
- R7: A retry during the burst returns the master to requesting, with `bus_sel` low. The unacknowledged byte and its address are presented again once the grant returns. No byte is lost or repeated.
- R8: In the cycle after a retry, `bus_lock` is high if `bus_grant` was high at the retry, and low otherwise.
- R9: An error acknowledge or a timeout during the burst drops `bus_sel`, `bus_lock` and `bus_req` in the next cycle and sets `err_status`. `err_status` stays set until the next `frame_start`.
- R10: Bytes reach the bus in the order they arrive. A byte offered while the FIFO holds `FIFO_DEPTH` bytes is dropped and sets `ovf_status`. `ovf_status` stays set until the next `frame_start`, which also empties the FIFO.
- R11: A new frame writes from `BASE_ADDR` again and carries only bytes pushed after its `frame_start`.
- R12: While the burst is running and the FIFO is empty, `bus_sel` is low and `bus_lock` stays high. There is no limit on how long this lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begins a frame. Acted on only while idle |
| pix_valid | input | 1 | Pixel byte strobe from the capture side |
| pix_data | input | DATA_W | Pixel byte |
| bus_grant | input | 1 | Arbiter grant |
| xfer_ack | input | 1 | Slave transfer acknowledge |
| xfer_retry | input | 1 | Slave asks for the burst to be restarted |
| err_ack | input | 1 | Slave error acknowledge |
| xfer_timeout | input | 1 | Bus timeout |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_sel | output | 1 | Master select; a beat is on the bus |
| bus_seq | output | 1 | Sequential-address flag; low on the final beat |
| bus_be | output | DATA_W/8 | Byte enables |
| bus_lock | output | 1 | Bus lock |
| bus_addr | output | ADDR_W | Write address |
| bus_wdata | output | DATA_W | Write data; zero when not selected |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| err_status | output | 1 | Sticky abort flag |
| ovf_status | output | 1 | Sticky FIFO overflow flag |

## Verification
The frame write is driven with several input patterns:
- **Free-flowing run.** All bytes are queued, the grant is held and every beat is acknowledged. This fixes the address ramp, the placement of the sequential flag and the done pulse.
- **Starved run.** The FIFO drains partway through the burst. This separates the select signal from the lock signal.
- **Retry with and without grant.** One retry comes while the grant is held and one while it is dropped. These show whether the lock is kept, and that the unacknowledged byte is replayed without loss or duplication.
- **Abort and overflow.** An error abort, a timeout abort and an overfilled FIFO show the sticky flags setting and clearing. A follow-on frame confirms the address returns to base and the stale bytes are discarded.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BURST = 2'd2
    } wr_state_e;
endpackage

// File: rtl/lbw_fifo.sv
module lbw_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              ovf_pulse
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_s;

    fifo_s f_q, f_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic wr_en, rd_en;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (f_q.cnt == '0);
    assign full      = (f_q.cnt == CNT_W'(DEPTH));
    assign rd_en     = pop && !empty && !flush;
    assign wr_en     = push && !flush && (!full || rd_en);
    assign ovf_pulse = push && !flush && full && !rd_en;
    assign head      = mem[f_q.rp];

    always_comb begin
        f_d = f_q;
        if (flush) begin
            f_d = '0;
        end else begin
            if (wr_en) f_d.wp = ptr_inc(f_q.wp);
            if (rd_en) f_d.rp = ptr_inc(f_q.rp);
            if (wr_en && !rd_en) f_d.cnt = f_q.cnt + 1'b1;
            if (rd_en && !wr_en) f_d.cnt = f_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[f_q.wp] <= push_data;
    end
endmodule

// File: rtl/lbw_ctrl.sv
module lbw_ctrl
    import lbw_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              DATA_W      = 8,
    parameter int              FRAME_BYTES = 640 * 480 * 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0010_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                bus_grant,
    input  logic                xfer_ack,
    input  logic                xfer_retry,
    input  logic                err_ack,
    input  logic                xfer_timeout,
    input  logic                fifo_empty,
    input  logic [DATA_W-1:0]   fifo_head,
    input  logic                fifo_ovf,
    output logic                fifo_pop,
    output logic                fifo_flush,
    output logic                bus_req,
    output logic                bus_sel,
    output logic                bus_seq,
    output logic [DATA_W/8-1:0] bus_be,
    output logic                bus_lock,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic                frame_done,
    output logic                err_status,
    output logic                ovf_status
);
    localparam int BE_W  = DATA_W / 8;
    localparam int STEP  = BE_W;
    localparam int CNT_W = $clog2(FRAME_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(FRAME_BYTES - 1);

    typedef struct packed {
        wr_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              relock;
        logic              err;
        logic              ovf;
        logic              done;
    } ctrl_s;

    ctrl_s r_q, r_d;
    logic  beat;

    assign bus_sel    = (r_q.st == ST_BURST) && !fifo_empty;
    assign bus_req    = (r_q.st == ST_REQ);
    assign bus_lock   = (r_q.st == ST_BURST) || ((r_q.st == ST_REQ) && r_q.relock);
    assign bus_seq    = bus_sel && (r_q.cnt != LAST_BEAT);
    assign bus_be     = {BE_W{bus_sel}};
    assign bus_wdata  = bus_sel ? fifo_head : '0;
    assign bus_addr   = r_q.addr;
    assign frame_done = r_q.done;
    assign err_status = r_q.err;
    assign ovf_status = r_q.ovf;

    assign beat       = bus_sel && xfer_ack && !xfer_retry && !err_ack && !xfer_timeout;
    assign fifo_pop   = beat;
    assign fifo_flush = (r_q.st == ST_IDLE) && frame_start;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.ovf  = r_q.ovf | fifo_ovf;
        unique case (r_q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    r_d.st     = ST_REQ;
                    r_d.addr   = BASE_ADDR;
                    r_d.cnt    = '0;
                    r_d.err    = 1'b0;
                    r_d.ovf    = 1'b0;
                    r_d.relock = 1'b0;
                end
            end
            ST_REQ: begin
                r_d.relock = 1'b0;
                if (bus_grant) r_d.st = ST_BURST;
            end
            ST_BURST: begin
                if (err_ack || xfer_timeout) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end else if (xfer_retry) begin
                    r_d.st     = ST_REQ;
                    r_d.relock = bus_grant;
                end else if (beat) begin
                    r_d.addr = r_q.addr + ADDR_W'(STEP);
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_BEAT) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: BASE_ADDR, cnt: '0,
                     relock: 1'b0, err: 1'b0, ovf: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/locked_burst_writer.sv
module locked_burst_writer #(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 32,
    parameter int                FIFO_DEPTH  = 16,
    parameter int                FRAME_BYTES = 640 * 480 * 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h0010_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                pix_valid,
    input  logic [DATA_W-1:0]   pix_data,
    input  logic                bus_grant,
    input  logic                xfer_ack,
    input  logic                xfer_retry,
    input  logic                err_ack,
    input  logic                xfer_timeout,
    output logic                bus_req,
    output logic                bus_sel,
    output logic                bus_seq,
    output logic [DATA_W/8-1:0] bus_be,
    output logic                bus_lock,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic                frame_done,
    output logic                err_status,
    output logic                ovf_status
);
    logic              f_flush, f_pop, f_empty, f_full, f_ovf;
    logic [DATA_W-1:0] f_head;

    lbw_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (f_flush),
        .push      (pix_valid),
        .push_data (pix_data),
        .pop       (f_pop),
        .head      (f_head),
        .empty     (f_empty),
        .full      (f_full),
        .ovf_pulse (f_ovf)
    );

    lbw_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FRAME_BYTES(FRAME_BYTES), .BASE_ADDR(BASE_ADDR)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .bus_grant    (bus_grant),
        .xfer_ack     (xfer_ack),
        .xfer_retry   (xfer_retry),
        .err_ack      (err_ack),
        .xfer_timeout (xfer_timeout),
        .fifo_empty   (f_empty),
        .fifo_head    (f_head),
        .fifo_ovf     (f_ovf),
        .fifo_pop     (f_pop),
        .fifo_flush   (f_flush),
        .bus_req      (bus_req),
        .bus_sel      (bus_sel),
        .bus_seq      (bus_seq),
        .bus_be       (bus_be),
        .bus_lock     (bus_lock),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .frame_done   (frame_done),
        .err_status   (err_status),
        .ovf_status   (ovf_status)
    );

    logic unused_full;
    assign unused_full = f_full;
endmodule

// File: rtl/locked_burst_writer_chk.sv
module locked_burst_writer_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_grant,
    input logic              xfer_ack,
    input logic              xfer_retry,
    input logic              err_ack,
    input logic              xfer_timeout,
    input logic              bus_req,
    input logic              bus_sel,
    input logic              bus_seq,
    input logic              bus_lock,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              frame_done,
    input logic              err_status
);
    // R2
    req_sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_sel));

    // R3
    grant_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_grant) |=> (!bus_req && bus_lock));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && xfer_ack && !xfer_retry && !err_ack && !xfer_timeout)
        |=> (bus_addr == $past(bus_addr) + 1'b1));

    // R5
    seq_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_seq |-> bus_sel);

    // R6
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_wdata == '0));

    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!bus_sel && !bus_lock));

    // R9
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && !bus_req && (err_ack || xfer_timeout))
        |=> (!bus_lock && !bus_sel && err_status));

    // R12
    sel_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> bus_lock);
endmodule

bind locked_burst_writer locked_burst_writer_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_grant    (bus_grant),
    .xfer_ack     (xfer_ack),
    .xfer_retry   (xfer_retry),
    .err_ack      (err_ack),
    .xfer_timeout (xfer_timeout),
    .bus_req      (bus_req),
    .bus_sel      (bus_sel),
    .bus_seq      (bus_seq),
    .bus_lock     (bus_lock),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .frame_done   (frame_done),
    .err_status   (err_status)
);

// File: tb/locked_burst_writer_tb_top.sv
`timescale 1ns/1ps
module locked_burst_writer_tb_top;
    localparam int          FRAME = 8;
    localparam logic [31:0] BASE  = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, pix_valid = 1'b0;
    logic [7:0]  pix_data = '0;
    logic        grant = 1'b0, ack_en = 1'b0, retry = 1'b0, err = 1'b0, tmo = 1'b0;
    logic        ack;
    logic        req, sel, seq, lock, done, err_st, ovf_st;
    logic [0:0]  be;
    logic [31:0] addr;
    logic [7:0]  wdata;

    int n_chk = 0, n_bad = 0;
    int beat_n = 0, mark = 0;
    logic [31:0] m_addr [256];
    logic [7:0]  m_data [256];
    logic        m_seq  [256];

    always #2.5 clk = ~clk;
    assign ack = sel & ack_en;

    locked_burst_writer #(
        .DATA_W(8), .ADDR_W(32), .FIFO_DEPTH(16),
        .FRAME_BYTES(FRAME), .BASE_ADDR(BASE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_data(pix_data), .bus_grant(grant),
        .xfer_ack(ack), .xfer_retry(retry), .err_ack(err), .xfer_timeout(tmo),
        .bus_req(req), .bus_sel(sel), .bus_seq(seq), .bus_be(be),
        .bus_lock(lock), .bus_addr(addr), .bus_wdata(wdata),
        .frame_done(done), .err_status(err_st), .ovf_status(ovf_st)
    );

    // bus beat monitor, mid-cycle
    always @(negedge clk) begin
        if (rst_n && sel && ack && !retry && !err && !tmo && beat_n < 256) begin
            m_addr[beat_n] = addr;
            m_data[beat_n] = wdata;
            m_seq[beat_n]  = seq;
            beat_n = beat_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic start_frame();
        step(); frame_start = 1'b1;
        step(); frame_start = 1'b0;
        mark = beat_n;
    endtask

    task automatic push(input int n, input logic [7:0] first);
        for (int i = 0; i < n; i++) begin
            step(); pix_valid = 1'b1; pix_data = first + 8'(i);
        end
        step(); pix_valid = 1'b0;
    endtask

    task automatic wait_done();
        bit seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
        chk("R6 done pulse seen", 32'(seen), 32'd1);
        if (seen) begin
            chk("R6 sel released at done", 32'(sel), 32'd0);
            chk("R6 be released at done", 32'(be), 32'd0);
            chk("R6 lock released at done", 32'(lock), 32'd0);
            chk("R6 data zero at done", 32'(wdata), 32'd0);
            @(negedge clk);
            chk("R6 done single cycle", 32'(done), 32'd0);
        end
    endtask

    task automatic check_frame(input logic [7:0] first);
        chk("R7 beat count", 32'(beat_n - mark), FRAME);
        for (int k = 0; k < FRAME && (mark + k) < 256; k++) begin
            chk("R4 beat address", m_addr[mark + k], BASE + 32'(k));
            chk("R10 beat data order", 32'(m_data[mark + k]), 32'(first + 8'(k)));
            chk("R5 seq flag", 32'(m_seq[mark + k]), (k == FRAME - 1) ? 32'd0 : 32'd1);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req", 32'(req), 0);   chk("R1 sel", 32'(sel), 0);
        chk("R1 seq", 32'(seq), 0);   chk("R1 be", 32'(be), 0);
        chk("R1 lock", 32'(lock), 0); chk("R1 data", 32'(wdata), 0);
        chk("R1 done", 32'(done), 0); chk("R1 err", 32'(err_st), 0);
        chk("R1 ovf", 32'(ovf_st), 0);
    endtask

    task automatic t_normal();
        start_frame();
        push(FRAME, 8'hA0);
        @(negedge clk);
        chk("R2 req held without grant", 32'(req), 1);
        chk("R2 no sel while requesting", 32'(sel), 0);
        step(); grant = 1'b1; ack_en = 1'b1;
        @(negedge clk);
        chk("R2 req until grant registered", 32'(req), 1);
        step();
        @(negedge clk);
        chk("R3 req dropped", 32'(req), 0);
        chk("R3 sel", 32'(sel), 1);
        chk("R3 lock", 32'(lock), 1);
        chk("R3 seq", 32'(seq), 1);
        chk("R3 be", 32'(be), 1);
        chk("R4 first address at base", addr, BASE);
        wait_done();
        check_frame(8'hA0);
        step(); grant = 1'b0; ack_en = 1'b0;
    endtask

    task automatic t_starve();
        start_frame();
        push(3, 8'hB0);
        grant = 1'b1; ack_en = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (beat_n - mark >= 3) break;
        end
        @(negedge clk);
        chk("R12 sel low when fifo empty", 32'(sel), 0);
        chk("R12 lock held when fifo empty", 32'(lock), 1);
        chk("R12 no re-request", 32'(req), 0);
        repeat (6) @(negedge clk);
        chk("R12 lock still held", 32'(lock), 1);
        chk("R4 address holds without ack", addr, BASE + 32'd3);
        push(5, 8'hB3);
        wait_done();
        check_frame(8'hB0);
        step(); grant = 1'b0; ack_en = 1'b0;
    endtask

    task automatic t_retry();
        start_frame();
        push(FRAME, 8'hC0);
        grant = 1'b1; ack_en = 1'b0;
        step();
        @(negedge clk);
        chk("R3 sel after grant", 32'(sel), 1);
        step();
        @(negedge clk);
        chk("R4 address holds without ack", addr, BASE);
        step(); ack_en = 1'b1;
        step(); step();
        step(); ack_en = 1'b0; retry = 1'b1;
        step(); retry = 1'b0;
        @(negedge clk);
        chk("R7 back to request", 32'(req), 1);
        chk("R7 sel low after retry", 32'(sel), 0);
        chk("R8 lock kept with grant", 32'(lock), 1);
        chk("R7 address of first unacked beat", addr, BASE + 32'd3);
        step();
        @(negedge clk);
        chk("R7 sel back", 32'(sel), 1);
        chk("R7 replayed byte", 32'(wdata), 32'hC3);
        step(); ack_en = 1'b1;
        step();
        step(); ack_en = 1'b0; retry = 1'b1; grant = 1'b0;
        step(); retry = 1'b0;
        @(negedge clk);
        chk("R7 request after second retry", 32'(req), 1);
        chk("R8 lock released without grant", 32'(lock), 0);
        chk("R7 address after second retry", addr, BASE + 32'd5);
        step();
        @(negedge clk);
        chk("R2 waits for grant", 32'(req), 1);
        chk("R2 no sel before grant", 32'(sel), 0);
        step(); grant = 1'b1; ack_en = 1'b1;
        wait_done();
        check_frame(8'hC0);
        step(); grant = 1'b0; ack_en = 1'b0;
    endtask

    task automatic t_abort();
        start_frame();
        push(6, 8'h60);
        grant = 1'b1; ack_en = 1'b0;
        step();
        step(); ack_en = 1'b1;
        step(); step(); ack_en = 1'b0; err = 1'b1;
        step(); err = 1'b0; grant = 1'b0;
        @(negedge clk);
        chk("R9 sel released on error", 32'(sel), 0);
        chk("R9 lock released on error", 32'(lock), 0);
        chk("R9 no request after error", 32'(req), 0);
        chk("R9 err status set", 32'(err_st), 1);
        chk("R9 beats before error", 32'(beat_n - mark), 2);
        repeat (3) step();
        @(negedge clk);
        chk("R9 err status sticky", 32'(err_st), 1);
        chk("R9 stays idle", 32'(req), 0);
        start_frame();
        @(negedge clk);
        chk("R9 err cleared by frame start", 32'(err_st), 0);
        push(2, 8'h70);
        grant = 1'b1;
        step(); tmo = 1'b1;
        step(); tmo = 1'b0; grant = 1'b0;
        @(negedge clk);
        chk("R9 sel released on timeout", 32'(sel), 0);
        chk("R9 lock released on timeout", 32'(lock), 0);
        chk("R9 err set on timeout", 32'(err_st), 1);
    endtask

    task automatic t_overflow();
        start_frame();
        push(16, 8'h80);
        @(negedge clk);
        chk("R10 no overflow at depth", 32'(ovf_st), 0);
        push(1, 8'h90);
        @(negedge clk);
        chk("R10 overflow flagged", 32'(ovf_st), 1);
        step(); grant = 1'b1; ack_en = 1'b1;
        wait_done();
        check_frame(8'h80);
        chk("R10 overflow sticky", 32'(ovf_st), 1);
        step(); grant = 1'b0; ack_en = 1'b0;
        start_frame();
        @(negedge clk);
        chk("R10 overflow cleared by frame start", 32'(ovf_st), 0);
        chk("R11 address reset to base", addr, BASE);
        push(FRAME, 8'hE0);
        grant = 1'b1; ack_en = 1'b1;
        wait_done();
        check_frame(8'hE0);   // R11 stale bytes flushed, base reused
        step(); grant = 1'b0; ack_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_starve();
        t_retry();
        t_abort();
        t_overflow();
        repeat (3) step();
        report();
        $finish;
    end
endmodule